// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Driver Core

This block is the digital heart of an LCD row driver with a parameterised number of drive outputs (240 by default). A scan token travels along a shift register that can move in either direction. One stage belongs to each drive output, and each drive output emits a 2-bit code that picks one of four bias levels. The register steps once for each falling edge of the line-pulse input `lp`, which is sampled on the system clock `clk`. The `dir` input picks the direction and swaps the roles of the two end pins. One end pin takes the serial input and the other presents the last stage, so several drivers can be chained in a cascade.

In dual mode, a second serial input `mid_in` enters at the midpoint, so each half of a split panel gets its own token. The drive levels are set by each stage bit together with the frame-inversion input `fr`. An active-low display-off input blanks every output to ground at once and clears the register asynchronously. Its release is synchronised, and shifting resumes only on a falling edge of `lp` seen after the release.

The data path is a plain pin-level interface with no handshake. Every stimulus is a level or a sampled edge, so there is no back-pressure to manage.

Top module: `lcd_row_scan_drv`

## Requirements
- R1: While `rst_n` or `disp_off_n` is low, every output code is VSS (2'b00) and every register stage is cleared to 0, both taking effect without waiting for a clock edge.
- R2: When not blanked, the code for output k is 2'b11 (V0) for a stage of 1 with `fr`=1, and 2'b00 (VSS) for a stage of 1 with `fr`=0. For a stage of 0 it is 2'b01 (V43) with `fr`=1 and 2'b10 (V12) with `fr`=0. Output k occupies bits [2k+1:2k] of `lvl_codes`, with k=0 for Y1.
- R3: With `dir`=1, a falling edge of `lp` (1 at one `clk` edge, 0 at the next) shifts stage k into stage k+1 at that second edge, and stage 0 (Y1) takes `eio1_in`.
- R4: With `dir`=0, a falling edge of `lp` shifts stage k+1 into stage k, and the last stage (Y240) takes `eio2_in`.
- R5: `eio1_oe` is 1 exactly when `dir`=0, and `eio2_oe` is 1 exactly when `dir`=1.
- R6: The enabled end pin presents the last stage in the shift direction: `eio2_out` = Y240 stage when `dir`=1, and `eio1_out` = Y1 stage when `dir`=0. A disabled end pin drives 0.
- R7: With `dual_mode`=1, `mid_in` is loaded on a shift instead of the neighbouring stage. The entry is stage NUM_OUT/2+1 (Y121) when `dir`=1 and stage NUM_OUT/2 (Y120) when `dir`=0, which is the (NUM_OUT/2+1)-th stage counted from the input end.
- R8: With `dual_mode`=0, `mid_in` has no effect, and the midpoint stages take their neighbour like every other stage.
- R9: Without a falling edge of `lp`, the register holds and the outputs change only with `fr`, whatever the serial inputs do.
- R10: After `disp_off_n` rises, outputs show the non-select level from the second `clk` edge on. The first capture needs `lp` to be seen high and then low after that release, so a fall that happened while blanked captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_off_n | input | 1 | Active-low display-off (blank and clear) |
| lp | input | 1 | Line-pulse shift clock, sampled on clk |
| dir | input | 1 | Shift direction: 1 = Y1 toward last, 0 = last toward Y1 |
| dual_mode | input | 1 | 1 = midpoint second data entry enabled |
| fr | input | 1 | Frame-inversion level |
| eio1_in | input | 1 | Serial input at the Y1 end (used when dir=1) |
| eio2_in | input | 1 | Serial input at the last end (used when dir=0) |
| mid_in | input | 1 | Midpoint serial input for dual mode |
| eio1_out | output | 1 | Y1 end cascade output |
| eio1_oe | output | 1 | Output enable of the Y1 end pin |
| eio2_out | output | 1 | Last end cascade output |
| eio2_oe | output | 1 | Output enable of the last end pin |
| lvl_codes | output | 2*NUM_OUT | Packed 2-bit level code per drive output |

## Verification
The bench builds the driver with NUM_OUT=16, so the midpoint entries are stages 9 and 8. With a register this short, a token crosses the whole chain and reaches both cascade pins within a few line pulses. The same short length lets random direction and mode changes take tokens across the midpoint entries in both directions many times. The display-off recovery cases, including a line-pulse fall hidden inside the blanking window, are driven directly.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_VSS = 2'b00,
    LVL_V43 = 2'b01,
    LVL_V12 = 2'b10,
    LVL_V0  = 2'b11
  } lvl_e;

  // selected rows drive the outer rails, unselected rows the inner ones
  function automatic lvl_e pick_level(input logic sel, input logic inv);
    if (sel) return inv ? LVL_V0 : LVL_VSS;
    else     return inv ? LVL_V43 : LVL_V12;
  endfunction
endpackage

// File: rtl/lcd_blank_ctrl.sv
module lcd_blank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_off_n,
  output logic clr_n,
  output logic ready
);
  logic s1, s2;

  assign clr_n = rst_n & disp_off_n;

  // immediate assertion of blanking, two-flop release
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end

  assign ready = s2;

  // R1
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> !ready);

  // R10
  release_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_off_n) |=> !ready);
endmodule

// File: rtl/lcd_lp_edge.sv
module lcd_lp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic lp,
  output logic step
);
  logic lp_d;

  // history is wiped while blanked, so only a fall seen after release counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lp_d <= 1'b0;
    else if (!ready) lp_d <= 1'b0;
    else             lp_d <= lp;
  end

  assign step = ready & lp_d & ~lp;

  // R10
  no_step_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ready) |-> !step);
endmodule

// File: rtl/lcd_shift_chain.sv
module lcd_shift_chain #(
  parameter int NUM_OUT = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               step,
  input  logic               dir,
  input  logic               dual_mode,
  input  logic               up_in,
  input  logic               dn_in,
  input  logic               mid_in,
  output logic [NUM_OUT-1:0] q
);
  localparam int UP_ENTRY = NUM_OUT / 2;
  localparam int DN_ENTRY = NUM_OUT / 2 - 1;

  logic [NUM_OUT-1:0] nxt;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_first
      assign from_low = up_in;
    end else if (i == UP_ENTRY) begin : g_up_mid
      assign from_low = dual_mode ? mid_in : q[i-1];
    end else begin : g_up_norm
      assign from_low = q[i-1];
    end
    if (i == NUM_OUT - 1) begin : g_last
      assign from_high = dn_in;
    end else if (i == DN_ENTRY) begin : g_dn_mid
      assign from_high = dual_mode ? mid_in : q[i+1];
    end else begin : g_dn_norm
      assign from_high = q[i+1];
    end
    assign nxt[i] = dir ? from_low : from_high;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    q <= '0;
    else if (step) q <= nxt;
  end

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (q == '0));

  // R3
  up_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (step && dir) |=> (q[0] == $past(up_in)) && (q[NUM_OUT-1] == $past(q[NUM_OUT-2])));

  // R4
  dn_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (step && !dir) |=> (q[NUM_OUT-1] == $past(dn_in)) && (q[0] == $past(q[1])));

  // R7
  mid_entry_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (step && dual_mode) |=> (q[$past(dir) ? UP_ENTRY : DN_ENTRY] == $past(mid_in)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !step |=> $stable(q));
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map #(
  parameter int NUM_OUT = 240
) (
  input  logic                                  ready,
  input  logic                                  fr,
  input  logic [NUM_OUT-1:0]                    q,
  output logic [NUM_OUT*lcd_scan_pkg::LVL_W-1:0] codes
);
  import lcd_scan_pkg::*;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
    assign codes[i*LVL_W +: LVL_W] = ready ? pick_level(q[i], fr) : LVL_VSS;
  end
endmodule

// File: rtl/lcd_row_scan_drv.sv
module lcd_row_scan_drv #(
  parameter int NUM_OUT = 240
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_off_n,
  input  logic                  lp,
  input  logic                  dir,
  input  logic                  dual_mode,
  input  logic                  fr,
  input  logic                  eio1_in,
  input  logic                  eio2_in,
  input  logic                  mid_in,
  output logic                  eio1_out,
  output logic                  eio1_oe,
  output logic                  eio2_out,
  output logic                  eio2_oe,
  output logic [2*NUM_OUT-1:0]  lvl_codes
);
  localparam int CODE_W = NUM_OUT * lcd_scan_pkg::LVL_W;

  logic clr_n, ready, step;
  logic [NUM_OUT-1:0] q;
  logic [CODE_W-1:0]  codes;

  lcd_blank_ctrl u_blank (
    .clk(clk), .rst_n(rst_n), .disp_off_n(disp_off_n),
    .clr_n(clr_n), .ready(ready)
  );

  lcd_lp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ready(ready), .lp(lp), .step(step)
  );

  lcd_shift_chain #(.NUM_OUT(NUM_OUT)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .step(step), .dir(dir),
    .dual_mode(dual_mode), .up_in(eio1_in), .dn_in(eio2_in),
    .mid_in(mid_in), .q(q)
  );

  lcd_level_map #(.NUM_OUT(NUM_OUT)) u_map (
    .ready(ready), .fr(fr), .q(q), .codes(codes)
  );

  assign lvl_codes = codes;

  // pin roles swap with direction; an input-role pin drives 0
  assign eio1_oe  = ~dir;
  assign eio2_oe  = dir;
  assign eio1_out = ~dir & q[0];
  assign eio2_out = dir & q[NUM_OUT-1];

  // R6
  cascade_out_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (step && dir) |=> (eio2_out == $past(q[NUM_OUT-2])) || !dir);
endmodule

// File: tb/lcd_row_scan_drv_tb_top.sv
module lcd_row_scan_drv_tb_top;
  localparam int N = 16;
  localparam int UPE = N / 2;
  localparam int DNE = N / 2 - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, disp_off_n = 1'b1, lp = 1'b0, dir = 1'b1, dual_mode = 1'b0;
  logic fr = 1'b0, eio1_in = 1'b0, eio2_in = 1'b0, mid_in = 1'b0;
  logic eio1_out, eio1_oe, eio2_out, eio2_oe;
  logic [2*N-1:0] lvl_codes;

  int total = 0, bad = 0;
  bit done = 0;
  logic [N-1:0] mdl = '0;

  always #10 clk = ~clk;

  lcd_row_scan_drv #(.NUM_OUT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_off_n(disp_off_n), .lp(lp), .dir(dir),
    .dual_mode(dual_mode), .fr(fr), .eio1_in(eio1_in), .eio2_in(eio2_in),
    .mid_in(mid_in), .eio1_out(eio1_out), .eio1_oe(eio1_oe),
    .eio2_out(eio2_out), .eio2_oe(eio2_oe), .lvl_codes(lvl_codes)
  );

  function automatic logic [2*N-1:0] exp_codes(input logic [N-1:0] m, input logic f, input logic on);
    logic [2*N-1:0] r;
    for (int k = 0; k < N; k++) begin
      if (!on)       r[2*k +: 2] = 2'b00;
      else if (m[k]) r[2*k +: 2] = f ? 2'b11 : 2'b00;
      else           r[2*k +: 2] = f ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] shift_model(input logic [N-1:0] m, input logic d,
      input logic du, input logic a, input logic b, input logic c);
    logic [N-1:0] r;
    if (d) begin
      r = {m[N-2:0], a};
      if (du) r[UPE] = c;
    end else begin
      r = {b, m[N-1:1]};
      if (du) r[DNE] = c;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic on);
    chk(req, 64'(lvl_codes), 64'(exp_codes(mdl, fr, on)));
    chk("R5", {62'd0, eio1_oe, eio2_oe}, {62'd0, ~dir, dir});
    chk("R6", {62'd0, eio1_out, eio2_out}, {62'd0, ~dir & mdl[0], dir & mdl[N-1]});
  endtask

  task automatic line_pulse();
    @(negedge clk); lp = 1'b1;
    @(negedge clk); lp = 1'b0;
    mdl = shift_model(mdl, dir, dual_mode, eio1_in, eio2_in, mid_in);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset", 64'(lvl_codes), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 release-early", 64'(lvl_codes), 64'd0);
    repeat (2) @(negedge clk);
    chk_state("R10 release", 1'b1);
    fr = 1'b1; #1;
    chk_state("R2 fr", 1'b1);

    // directed: token up from Y1, reaches the cascade pin
    dir = 1'b1; eio1_in = 1'b1; line_pulse(); eio1_in = 1'b0;
    chk_state("R3 token in", 1'b1);
    for (int k = 1; k < N; k++) line_pulse();
    chk_state("R6 token at end", 1'b1);
    line_pulse();
    chk_state("R3 token out", 1'b1);

    // directed: downward token
    dir = 1'b0; eio2_in = 1'b1; line_pulse(); eio2_in = 1'b0;
    for (int k = 1; k < N; k++) line_pulse();
    chk_state("R4 token at Y1", 1'b1);

    // single mode ignores midpoint input
    dual_mode = 1'b0; mid_in = 1'b1; line_pulse();
    chk_state("R8 mid ignored", 1'b1);
    // dual mode entries, both directions
    dual_mode = 1'b1; dir = 1'b1; line_pulse();
    chk_state("R7 up entry", 1'b1);
    dir = 1'b0; line_pulse();
    chk_state("R7 down entry", 1'b1);
    mid_in = 1'b0; dual_mode = 1'b0;

    // hold without lp fall
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      eio1_in = 1'($urandom); eio2_in = 1'($urandom); mid_in = 1'($urandom);
      dir = 1'($urandom); fr = 1'($urandom);
    end
    @(negedge clk);
    chk_state("R9 hold", 1'b1);

    // display-off with an lp fall hidden inside the blanking window
    dir = 1'b1; eio1_in = 1'b1; dual_mode = 1'b0;
    lp = 1'b1; @(negedge clk);
    disp_off_n = 1'b0; #1;
    chk("R1 blank now", 64'(lvl_codes), 64'd0);
    mdl = '0;
    @(negedge clk); lp = 1'b0;
    repeat (2) @(negedge clk);
    disp_off_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_state("R10 no stale capture", 1'b1);
    line_pulse();
    chk_state("R10 first capture", 1'b1);
    eio1_in = 1'b0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      dir = 1'($urandom); dual_mode = 1'($urandom); fr = 1'($urandom);
      eio1_in = 1'($urandom); eio2_in = 1'($urandom); mid_in = 1'($urandom);
      line_pulse();
      if (dual_mode) chk_state("R7 random", 1'b1);
      else if (dir)  chk_state("R3 random", 1'b1);
      else           chk_state("R4 random", 1'b1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule